// File: doc/BRIEF.md
# Register Transfer Move Unit

This unit carries out the register-to-register move instructions of a small processor with 16-bit instruction words. It owns two banks of eight 16-bit registers, the general registers and the memory pointers. It also owns three special registers: a status register, a memory data buffer and an interrupt vector base. A fetched word is offered on `instrValid`/`instrWord`. A word with the move opcode is taken while the unit is idle. The unit then runs one execute cycle, or several in multi-word mode, and writes the destination at the rising edge that closes each execute cycle.

A multi-word move copies a run of consecutive registers. The source and destination indices both advance by one per execute cycle and wrap within the bank. The memory side of the processor fills the memory data buffer through a load input. The three special registers are driven out as plain outputs. A special read with a reserved or read-protected address writes nothing and raises a one-cycle illegal flag.

Top module: `regMoveUnit`

## Requirements
- R1: A word is taken only when `instrValid` is high, `busy` is low and bits [15:12] equal 4'b0011; `busy` rises at the next edge. Words with any other opcode leave `busy` low and change no register.
- R2: A regular move (bit 3 = 0) copies source register bits [7:5] of the bank chosen by bit 4 into destination register bits [10:8] of the bank chosen by bit 11. A bank bit of 0 selects the general registers and 1 selects the memory pointers.
- R3: A special read (bit 3 = 1, bit 2 = 0) copies the special register at bits [1:0] into the register named by bits [11:8]. Bit 11 selects the bank and bits [10:8] the index. Address 01 is status and 10 is the memory data buffer.
- R4: A special write (bit 3 = 1, bit 2 = 1) copies the register named by bits [7:4] into the special register at bits [1:0]. Bit 7 selects the bank and bits [6:4] the index. Address 01 is status, 10 is the memory data buffer and 11 is the interrupt vector base.
- R5: A special move with address 00, or a special read of address 11, changes no register. `illegalFlag` is high for exactly its single execute cycle.
- R6: A single move keeps `busy` high for one cycle, with `done` high in that cycle. The result is visible on the following cycle.
- R7: With `multiWord` high, a regular move runs `moveCount`+1 execute cycles. It copies source index s+k to destination index d+k modulo 8, reading each source in its own cycle. `busy` stays high until the last transfer and `done` marks only the last cycle. Special moves ignore `multiWord`.
- R8: `instrValid` is ignored while `busy` is high.
- R9: Synchronous active-high reset clears all registers and `busy`.
- R10: `mdbLoad` writes `mdbLoadData` into the memory data buffer. A move that writes the buffer in the same cycle takes precedence.
- R11: Bits [2:0] of a regular move have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instrValid | input | 1 | Fetched word present |
| instrWord | input | 16 | Fetched instruction word |
| multiWord | input | 1 | Multi-word move request |
| moveCount | input | 3 | Registers to move minus one |
| mdbLoad | input | 1 | Memory-side buffer load strobe |
| mdbLoadData | input | 16 | Memory-side buffer load value |
| busy | output | 1 | Execute cycles in progress |
| done | output | 1 | Last execute cycle |
| illegalFlag | output | 1 | Illegal special move in execute |
| statusReg | output | 16 | Status register |
| memDataBuf | output | 16 | Memory data buffer |
| intVecBase | output | 16 | Interrupt vector base |

## Verification
Registers are seeded from the memory-buffer load path. Their contents are then read back by moving them into the status register, so every transfer type is judged at the ports. Random regular moves draw all four bank pairings, arbitrary bits [2:0] and runs of one to eight registers. These runs include overlapping and wrapping index ranges, which separate a per-cycle read from a snapshot of the source bank. Directed cases cover each special address in both directions, the reserved and read-protected addresses, an offered word while busy, and a buffer load colliding with a buffer write.

// File: rtl/rmu_pkg.sv
package rmu_pkg;
  localparam int IDX_W = 3;
  localparam int REG_COUNT = 1 << IDX_W;
  localparam logic [3:0] MOVE_OPC = 4'b0011;
  localparam logic [1:0] SP_STATUS = 2'b01;
  localparam logic [1:0] SP_MDB = 2'b10;
  localparam logic [1:0] SP_IVB = 2'b11;

  typedef struct packed {
    logic             exec;
    logic             last;
    logic             illegal;
    logic             regWrite;
    logic             dstBank;
    logic [IDX_W-1:0] dstIdx;
    logic             srcBank;
    logic [IDX_W-1:0] srcIdx;
    logic             useSpecial;
    logic             spWrite;
    logic [1:0]       spSel;
  } xferStrobe_t;
endpackage

// File: rtl/rmuCtrl.sv
module rmuCtrl
  import rmu_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instrValid,
  input  logic [15:0]       instrWord,
  input  logic              multiWord,
  input  logic [CNT_W-1:0]  moveCount,
  output xferStrobe_t       strobe,
  output logic              busy
);
  logic              busyQ;
  logic [15:0]       instrQ;
  logic [CNT_W-1:0]  remainQ;
  logic [IDX_W-1:0]  offsetQ;
  logic              accept;
  logic              isSpecial;
  logic              spDir;
  logic [1:0]        spAddr;
  logic              badSpecial;

  assign accept = instrValid && !busyQ && (instrWord[15:12] == MOVE_OPC);

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ   <= 1'b0;
      instrQ  <= '0;
      remainQ <= '0;
      offsetQ <= '0;
    end else if (accept) begin
      busyQ   <= 1'b1;
      instrQ  <= instrWord;
      remainQ <= (multiWord && !instrWord[3]) ? moveCount : '0;
      offsetQ <= '0;
    end else if (busyQ) begin
      if (remainQ == '0) begin
        busyQ <= 1'b0;
      end else begin
        remainQ <= remainQ - 1'b1;
        offsetQ <= offsetQ + 1'b1;
      end
    end
  end

  assign isSpecial  = instrQ[3];
  assign spDir      = instrQ[2];
  assign spAddr     = instrQ[1:0];
  assign badSpecial = isSpecial && ((spAddr == 2'b00) || (!spDir && spAddr == SP_IVB));
  assign busy       = busyQ;

  always_comb begin
    strobe            = '0;
    strobe.exec       = busyQ;
    strobe.last       = busyQ && (remainQ == '0);
    strobe.illegal    = busyQ && badSpecial;
    strobe.spSel      = spAddr;
    strobe.dstBank    = instrQ[11];
    strobe.dstIdx     = instrQ[10:8] + offsetQ;
    if (!isSpecial) begin
      strobe.regWrite = busyQ;
      strobe.srcBank  = instrQ[4];
      strobe.srcIdx   = instrQ[7:5] + offsetQ;
    end else if (!spDir) begin
      strobe.regWrite   = busyQ && !badSpecial;
      strobe.useSpecial = 1'b1;
    end else begin
      strobe.spWrite  = busyQ && !badSpecial;
      strobe.srcBank  = instrQ[7];
      strobe.srcIdx   = instrQ[6:4];
    end
  end
endmodule

// File: rtl/rmuDatapath.sv
module rmuDatapath
  import rmu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  xferStrobe_t       strobe,
  input  logic              mdbLoad,
  input  logic [DATA_W-1:0] mdbLoadData,
  output logic [DATA_W-1:0] statusReg,
  output logic [DATA_W-1:0] memDataBuf,
  output logic [DATA_W-1:0] intVecBase
);
  logic [DATA_W-1:0] gprQ [REG_COUNT];
  logic [DATA_W-1:0] mpQ  [REG_COUNT];
  logic [DATA_W-1:0] statusQ, mdbQ, ivbQ;
  logic [DATA_W-1:0] srcVal, spVal, wrVal;

  assign srcVal = strobe.srcBank ? mpQ[strobe.srcIdx] : gprQ[strobe.srcIdx];

  always_comb begin
    case (strobe.spSel)
      SP_STATUS: spVal = statusQ;
      SP_MDB:    spVal = mdbQ;
      default:   spVal = '0;
    endcase
  end

  assign wrVal = strobe.useSpecial ? spVal : srcVal;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_COUNT; i++) begin
        gprQ[i] <= '0;
        mpQ[i]  <= '0;
      end
    end else if (strobe.regWrite) begin
      if (strobe.dstBank) mpQ[strobe.dstIdx] <= wrVal;
      else                gprQ[strobe.dstIdx] <= wrVal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusQ <= '0;
      mdbQ    <= '0;
      ivbQ    <= '0;
    end else begin
      if (strobe.spWrite && strobe.spSel == SP_STATUS) statusQ <= srcVal;
      if (strobe.spWrite && strobe.spSel == SP_IVB)    ivbQ    <= srcVal;
      if (strobe.spWrite && strobe.spSel == SP_MDB)    mdbQ    <= srcVal;
      else if (mdbLoad)                                mdbQ    <= mdbLoadData;
    end
  end

  assign statusReg  = statusQ;
  assign memDataBuf = mdbQ;
  assign intVecBase = ivbQ;
endmodule

// File: rtl/regMoveUnit.sv
module regMoveUnit
  import rmu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instrValid,
  input  logic [15:0]       instrWord,
  input  logic              multiWord,
  input  logic [CNT_W-1:0]  moveCount,
  input  logic              mdbLoad,
  input  logic [DATA_W-1:0] mdbLoadData,
  output logic              busy,
  output logic              done,
  output logic              illegalFlag,
  output logic [DATA_W-1:0] statusReg,
  output logic [DATA_W-1:0] memDataBuf,
  output logic [DATA_W-1:0] intVecBase
);
  xferStrobe_t strobe;

  rmuCtrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .multiWord(multiWord), .moveCount(moveCount), .strobe(strobe), .busy(busy)
  );

  rmuDatapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .mdbLoad(mdbLoad),
    .mdbLoadData(mdbLoadData), .statusReg(statusReg), .memDataBuf(memDataBuf),
    .intVecBase(intVecBase)
  );

  assign done        = strobe.last;
  assign illegalFlag = strobe.illegal;
endmodule

// File: rtl/rmuChecker.sv
module rmuChecker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              instrValid,
  input logic [15:0]       instrWord,
  input logic              busy,
  input logic              done,
  input logic              illegalFlag,
  input logic [DATA_W-1:0] statusReg,
  input logic [DATA_W-1:0] intVecBase
);
  a_r1_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy && instrValid && instrWord[15:12] == 4'b0011) |=> busy);
  a_r1_ignore: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(instrValid && instrWord[15:12] == 4'b0011)) |=> !busy);
  a_r5_pulse: assert property (@(posedge clk) disable iff (rst)
    illegalFlag |=> !illegalFlag);
  a_r5_no_write: assert property (@(posedge clk) disable iff (rst)
    illegalFlag |=> ($stable(statusReg) && $stable(intVecBase)));
  a_r6_done_in_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  a_r7_hold_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
  a_r8_end_after_done: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (!busy && statusReg == '0 && intVecBase == '0));
endmodule

bind regMoveUnit rmuChecker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
  .busy(busy), .done(done), .illegalFlag(illegalFlag),
  .statusReg(statusReg), .intVecBase(intVecBase)
);

// File: tb/regMoveUnit_tb_top.sv
module regMoveUnit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic        multiWord = 1'b0;
  logic [2:0]  moveCount = '0;
  logic        mdbLoad = 1'b0;
  logic [15:0] mdbLoadData = '0;
  logic        busy, done, illegalFlag;
  logic [15:0] statusReg, memDataBuf, intVecBase;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [15:0] gprM [8];
  logic [15:0] mpM  [8];
  logic [15:0] srM, mdbM, ivbM;

  always #4 clk = ~clk;

  regMoveUnit dut_i (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .multiWord(multiWord), .moveCount(moveCount), .mdbLoad(mdbLoad),
    .mdbLoadData(mdbLoadData), .busy(busy), .done(done), .illegalFlag(illegalFlag),
    .statusReg(statusReg), .memDataBuf(memDataBuf), .intVecBase(intVecBase)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rdReg(input logic bank, input logic [2:0] idx);
    return bank ? mpM[idx] : gprM[idx];
  endfunction

  function automatic void wrReg(input logic bank, input logic [2:0] idx, input logic [15:0] v);
    if (bank) mpM[idx] = v;
    else gprM[idx] = v;
  endfunction

  function automatic int runLen(input logic [15:0] w, input logic mw, input logic [2:0] cnt);
    return (mw && !w[3]) ? int'(cnt) + 1 : 1;
  endfunction

  function automatic logic isIllegal(input logic [15:0] w);
    return w[3] && (w[1:0] == 2'b00 || (!w[2] && w[1:0] == 2'b11));
  endfunction

  function automatic void applyModel(input logic [15:0] w, input logic mw, input logic [2:0] cnt,
                                     input logic collide, input logic [15:0] cdata);
    logic mdbHit = 1'b0;
    if (w[15:12] != 4'b0011) return;
    if (!w[3]) begin
      for (int k = 0; k < runLen(w, mw, cnt); k++) begin
        logic [2:0] s = w[7:5] + 3'(k);
        logic [2:0] d = w[10:8] + 3'(k);
        wrReg(w[11], d, rdReg(w[4], s));
      end
    end else if (!isIllegal(w)) begin
      if (!w[2]) begin
        wrReg(w[11], w[10:8], (w[1:0] == 2'b01) ? srM : mdbM);
      end else begin
        logic [15:0] v = rdReg(w[7], w[6:4]);
        case (w[1:0])
          2'b01: srM = v;
          2'b10: begin mdbM = v; mdbHit = 1'b1; end
          default: ivbM = v;
        endcase
      end
    end
    if (collide && !mdbHit) mdbM = cdata;
  endfunction

  task automatic runMove(input string tag, input logic [15:0] w, input logic mw,
                         input logic [2:0] cnt, input logic collide, input logic [15:0] cdata);
    int n = runLen(w, mw, cnt);
    logic ill = isIllegal(w);
    @(negedge clk);
    instrValid = 1'b1; instrWord = w; multiWord = mw; moveCount = cnt;
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      check({tag, " busy"}, 16'(busy), 16'(1));
      check({tag, " done"}, 16'(done), 16'(k == n - 1));
      check({tag, " illegalFlag R5"}, 16'(illegalFlag), 16'(ill));
      mdbLoad = (collide && k == 0);
      mdbLoadData = cdata;
      if (k == 0 && n > 1) begin
        instrValid = 1'b1;                       // R8: offered while busy
        instrWord = {4'b0011, 12'($urandom)};
      end else begin
        instrValid = 1'b0;
      end
      @(negedge clk);
    end
    instrValid = 1'b0; mdbLoad = 1'b0; multiWord = 1'b0;
    check({tag, " busy end R6"}, 16'(busy), 16'(0));
    applyModel(w, mw, cnt, collide, cdata);
    check({tag, " status"}, statusReg, srM);
    check({tag, " mdb R10"}, memDataBuf, mdbM);
    check({tag, " ivb R4"}, intVecBase, ivbM);
  endtask

  task automatic observe(input string tag, input logic bank, input logic [2:0] idx);
    logic [15:0] exp = rdReg(bank, idx);
    runMove({tag, " obs"}, {4'b0011, 4'($urandom), bank, idx, 4'b1101}, 1'b0, 3'd0, 1'b0, '0);
    check({tag, " readback"}, statusReg, exp);
  endtask

  task automatic loadMdb(input logic [15:0] v);
    @(negedge clk);
    mdbLoad = 1'b1; mdbLoadData = v;
    @(negedge clk);
    mdbLoad = 1'b0;
    mdbM = v;
    check("R10 load", memDataBuf, v);
  endtask

  task automatic seedReg(input logic bank, input logic [2:0] idx, input logic [15:0] v);
    loadMdb(v);
    runMove("R3 mdb read", {4'b0011, bank, idx, 4'($urandom), 4'b1010}, 1'b0, 3'd0, 1'b0, '0);
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'h5EED_1234);
    for (int i = 0; i < 8; i++) begin gprM[i] = '0; mpM[i] = '0; end
    srM = '0; mdbM = '0; ivbM = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 busy", 16'(busy), 16'(0));
    check("R9 status", statusReg, '0);
    check("R9 mdb", memDataBuf, '0);
    check("R9 ivb", intVecBase, '0);
    observe("R9 gpr3", 1'b0, 3'd3);
    observe("R9 mp6", 1'b1, 3'd6);

    // R1: non-move opcode ignored
    @(negedge clk);
    instrValid = 1'b1; instrWord = 16'h4A5D;
    @(negedge clk);
    instrValid = 1'b0;
    check("R1 other opcode busy", 16'(busy), 16'(0));
    check("R1 other opcode status", statusReg, srM);

    for (int i = 0; i < 8; i++) begin
      seedReg(1'b0, 3'(i), 16'($urandom));
      seedReg(1'b1, 3'(i), 16'($urandom));
    end
    for (int i = 0; i < 8; i++) begin
      observe("R3 gpr", 1'b0, 3'(i));
      observe("R3 mp", 1'b1, 3'(i));
    end

    // R3 status read into MP, R4 writes of each special
    runMove("R3 status read", {4'b0011, 1'b1, 3'd2, 4'h0, 4'b1001}, 1'b0, 3'd0, 1'b0, '0);
    observe("R3 mp2", 1'b1, 3'd2);
    runMove("R4 ivb write", {4'b0011, 4'h0, 1'b1, 3'd5, 4'b1111}, 1'b0, 3'd0, 1'b0, '0);
    runMove("R4 mdb write", {4'b0011, 4'h0, 1'b0, 3'd4, 4'b1110}, 1'b0, 3'd0, 1'b0, '0);
    // R5 illegal cases
    runMove("R5 ivb read", {4'b0011, 1'b0, 3'd1, 4'h0, 4'b1011}, 1'b0, 3'd0, 1'b0, '0);
    observe("R5 gpr1", 1'b0, 3'd1);
    runMove("R5 addr00 read", {4'b0011, 1'b1, 3'd0, 4'h0, 4'b1000}, 1'b0, 3'd0, 1'b0, '0);
    observe("R5 mp0", 1'b1, 3'd0);
    runMove("R5 addr00 write", {4'b0011, 4'h0, 1'b0, 3'd7, 4'b1100}, 1'b0, 3'd0, 1'b0, '0);
    // R10 collision: move writing buffer wins
    runMove("R10 collide", {4'b0011, 4'h0, 1'b1, 3'd3, 4'b1110}, 1'b0, 3'd0, 1'b1, 16'hDEAD);
    // R7 full wrapping overlap run, R2 GPR->GPR
    runMove("R7 wrap run", {4'b0011, 1'b0, 3'd6, 3'd5, 1'b0, 4'b0101}, 1'b1, 3'd7, 1'b0, '0);
    for (int i = 0; i < 8; i++) observe("R7 wrap gpr", 1'b0, 3'(i));
    // R7 special ignores multiWord
    runMove("R7 special single", {4'b0011, 4'h0, 1'b1, 3'd1, 4'b1101}, 1'b1, 3'd5, 1'b0, '0);

    for (int it = 0; it < 250; it++) begin
      int kind = $urandom_range(0, 9);
      if (kind < 6) begin
        logic [15:0] w = {4'b0011, 12'($urandom)};
        w[3] = 1'b0;                              // regular, R11 bits [2:0] random
        runMove("R2 R7 R11 regular", w, 1'($urandom), 3'($urandom), 1'($urandom), 16'($urandom));
        observe("R2 dst", w[11], w[10:8]);
      end else if (kind < 8) begin
        logic [15:0] w = {4'b0011, 8'($urandom), 1'b1, 3'($urandom)};
        runMove("R3 R4 R5 special", w, 1'($urandom), 3'($urandom), 1'($urandom), 16'($urandom));
      end else if (kind == 8) begin
        loadMdb(16'($urandom));
      end else begin
        observe("R2 random", 1'($urandom), 3'($urandom));
      end
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule